// File: doc/BRIEF.md
# Lockstep SIMD Processing-Element Array

This block is a row of identical processing elements (PEs) under one control point. An external host runs the program and pushes one data-processing instruction per cycle into the array. Each accepted instruction is applied in the same cycle by every PE to its own local register file, so all PEs stay in lockstep. Each PE holds sixteen 16-bit registers, a small ALU (add, subtract, move, unsigned greater-than compare) and a one-bit condition flag.

Data-dependent `if/else` code is flattened into straight-line code. A compare sets each PE's flag. A mask-push instruction narrows the set of enabled PEs to those whose flag is set. A mask-flip instruction swaps to the complementary set for the else-part. A mask-pop instruction restores the enclosing set. Both branches therefore run one after the other on the whole array, and a disabled PE spends those cycles idle. Nesting is bounded by a small mask stack with a sticky overflow indication. A side port lets the host load and read any register of any PE. A stop instruction ends the stream and raises `done`.

Top module: `simd_array`

Instruction word (16 bits): `[15:12]` opcode, `[11:8]` destination register, `[7:4]` operand A register, `[3:0]` operand B register. Opcodes: 0 no-op, 1 add (`rd = A + B`), 2 subtract (`rd = A - B`, modulo 2^16), 3 move (`rd = A`), 4 compare (`flag = A > B`, unsigned), 5 mask push, 6 mask flip, 7 mask pop, 15 stop. Unlisted codes act as no-ops.

## Requirements
- R1: After synchronous reset every register of every PE reads 0, `done` is 0, `instr_ready` is 1, `stack_ovf` is 0, the mask stack is empty and all PEs are enabled.
- R2: An accepted add, subtract or move writes `rd` in every enabled PE, using that PE's own operands; the new value is readable through the side port from the next cycle.
- R3: An accepted compare sets each enabled PE's flag to (A > B) unsigned; disabled PEs keep their flag.
- R4: Opcode 5 pushes (current mask AND flag) and records the flag. While a PE is masked off, instructions write none of its registers.
- R5: Opcode 6 replaces the top mask with (enclosing mask AND NOT the flag recorded by the matching push); the enclosing mask is all ones at the outermost level.
- R6: Opcode 7 pops one level and restores the enclosing mask; a pop on an empty stack is ignored; the stack holds at most 4 levels.
- R7: A push while 4 levels are held leaves the stack and mask unchanged and sets `stack_ovf` the next cycle; it stays set until reset.
- R8: Before stop, `instr_ready` is high every cycle and back-to-back instructions complete one per cycle, each seeing the result of the one before.
- R9: `done` rises in the cycle after a stop is accepted and stays high; from then `instr_ready` is low and no further instruction has effect.
- R10: A side-port write (`ls_en=1`, `ls_we=1`) sets register `ls_addr` of PE `ls_pe`; a read (`ls_we=0`) returns that register on `ls_rdata` one cycle later.
- R11: With `instr_valid` low the instruction word has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is valid |
| instr_ready | output | 1 | Array accepts an instruction this cycle |
| instr_word | input | 16 | Broadcast instruction |
| ls_en | input | 1 | Side-port access enable |
| ls_we | input | 1 | Side-port write (1) or read (0) |
| ls_pe | input | 3 | Target PE index |
| ls_addr | input | 4 | Target register index |
| ls_wdata | input | 16 | Side-port write data |
| ls_rdata | output | 16 | Side-port read data, one cycle after the read |
| done | output | 1 | Stop instruction has been accepted |
| stack_ovf | output | 1 | Sticky mask-stack overflow |

## Verification
A wrong mask level only shows up at the ports when a later instruction writes a register. The checks therefore preload every destination with a marker value and read all eight PEs afterwards, so a wrong enable shows as a marker that should have been overwritten or a result where the marker should remain. This is visible two cycles after the faulty instruction: one cycle for the write and one for the registered read. Nested conditionals, a flip after an inner compare, a pop on an empty stack and a push past full are each followed by a marked write. A flag, depth or mask error that would otherwise hide inside the stack is thus exposed at the side port.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int DW     = 16;
    localparam int NREG   = 16;
    localparam int REG_AW = $clog2(NREG);

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_ADD     = 4'd1,
        OP_SUB     = 4'd2,
        OP_MOV     = 4'd3,
        OP_CMPGT   = 4'd4,
        OP_SETMASK = 4'd5,
        OP_ELSE    = 4'd6,
        OP_ENDIF   = 4'd7,
        OP_HALT    = 4'd15
    } opcode_t;

    typedef struct packed {
        opcode_t           op;
        logic [REG_AW-1:0] rd;
        logic [REG_AW-1:0] ra;
        logic [REG_AW-1:0] rb;
    } instr_t;

    localparam int IW = $bits(instr_t);

    function automatic logic writes_reg(opcode_t op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MOV);
    endfunction

    function automatic logic [DW-1:0] alu_result(opcode_t op, logic [DW-1:0] a, logic [DW-1:0] b);
        case (op)
            OP_ADD:  return a + b;
            OP_SUB:  return a - b;
            default: return a;
        endcase
    endfunction

endpackage

// File: rtl/simd_pe.sv
module simd_pe
    import simd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  instr_t            instr,
    input  logic              active,
    input  logic              ls_wr,
    input  logic [REG_AW-1:0] ls_addr,
    input  logic [DW-1:0]     ls_wdata,
    output logic [DW-1:0]     ls_rdata,
    output logic              flag
);

    logic [DW-1:0] rf [NREG];
    logic [DW-1:0] opa;
    logic [DW-1:0] opb;
    logic          go;

    assign opa      = rf[instr.ra];
    assign opb      = rf[instr.rb];
    assign ls_rdata = rf[ls_addr];
    assign go       = issue && active;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NREG; k++) begin
                rf[k] <= '0;
            end
            flag <= 1'b0;
        end else begin
            if (go && writes_reg(instr.op)) begin
                rf[instr.rd] <= alu_result(instr.op, opa, opb);
            end
            if (go && instr.op == OP_CMPGT) begin
                flag <= (opa > opb);
            end
            if (ls_wr) begin
                rf[ls_addr] <= ls_wdata;
            end
        end
    end

endmodule

// File: rtl/simd_mask_stack.sv
module simd_mask_stack
    import simd_pkg::*;
#(
    parameter  int NUM_PE    = 8,
    parameter  int STK_DEPTH = 4,
    localparam int DEP_W     = $clog2(STK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              flip,
    input  logic              pop,
    input  logic [NUM_PE-1:0] cond,
    output logic [NUM_PE-1:0] cur_mask,
    output logic [DEP_W-1:0]  depth,
    output logic              overflow
);

    logic [NUM_PE-1:0] mask_q [STK_DEPTH];
    logic [NUM_PE-1:0] cond_q [STK_DEPTH];
    logic [DEP_W-1:0]  depth_q;
    logic              ovf_q;
    logic [NUM_PE-1:0] parent;
    logic [NUM_PE-1:0] top_cond;
    logic              full;
    logic              empty;

    assign full     = (depth_q == DEP_W'(STK_DEPTH));
    assign empty    = (depth_q == '0);
    assign depth    = depth_q;
    assign overflow = ovf_q;

    always_comb begin
        cur_mask = '1;
        parent   = '1;
        top_cond = '0;
        for (int k = 0; k < STK_DEPTH; k++) begin
            if (depth_q == DEP_W'(k + 1)) begin
                cur_mask = mask_q[k];
                top_cond = cond_q[k];
            end
            if (depth_q == DEP_W'(k + 2)) begin
                parent = mask_q[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= '0;
            ovf_q   <= 1'b0;
            for (int k = 0; k < STK_DEPTH; k++) begin
                mask_q[k] <= '0;
                cond_q[k] <= '0;
            end
        end else if (push) begin
            if (full) begin
                ovf_q <= 1'b1;
            end else begin
                for (int k = 0; k < STK_DEPTH; k++) begin
                    if (depth_q == DEP_W'(k)) begin
                        mask_q[k] <= cur_mask & cond;
                        cond_q[k] <= cond;
                    end
                end
                depth_q <= depth_q + 1'b1;
            end
        end else if (flip && !empty) begin
            for (int k = 0; k < STK_DEPTH; k++) begin
                if (depth_q == DEP_W'(k + 1)) begin
                    mask_q[k] <= parent & ~top_cond;
                end
            end
        end else if (pop && !empty) begin
            depth_q <= depth_q - 1'b1;
        end
    end

endmodule

// File: rtl/simd_array.sv
module simd_array
    import simd_pkg::*;
#(
    parameter  int NUM_PE    = 8,
    parameter  int STK_DEPTH = 4,
    localparam int PE_AW     = $clog2(NUM_PE),
    localparam int DEP_W     = $clog2(STK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    output logic              instr_ready,
    input  logic [IW-1:0]     instr_word,
    input  logic              ls_en,
    input  logic              ls_we,
    input  logic [PE_AW-1:0]  ls_pe,
    input  logic [REG_AW-1:0] ls_addr,
    input  logic [DW-1:0]     ls_wdata,
    output logic [DW-1:0]     ls_rdata,
    output logic              done,
    output logic              stack_ovf
);

    instr_t            instr_s;
    logic              accept;
    logic              done_q;
    logic [NUM_PE-1:0] cur_mask;
    logic [NUM_PE-1:0] flags;
    logic [DEP_W-1:0]  stk_depth;
    logic [DW-1:0]     pe_rdata [NUM_PE];

    assign instr_s     = instr_t'(instr_word);
    assign instr_ready = !done_q;
    assign accept      = instr_valid && instr_ready;
    assign done        = done_q;

    generate
        for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
            simd_pe u_pe (
                .clk      (clk),
                .rst      (rst),
                .issue    (accept),
                .instr    (instr_s),
                .active   (cur_mask[g]),
                .ls_wr    (ls_en && ls_we && (ls_pe == PE_AW'(g))),
                .ls_addr  (ls_addr),
                .ls_wdata (ls_wdata),
                .ls_rdata (pe_rdata[g]),
                .flag     (flags[g])
            );
        end
    endgenerate

    simd_mask_stack #(
        .NUM_PE    (NUM_PE),
        .STK_DEPTH (STK_DEPTH)
    ) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (accept && instr_s.op == OP_SETMASK),
        .flip     (accept && instr_s.op == OP_ELSE),
        .pop      (accept && instr_s.op == OP_ENDIF),
        .cond     (flags),
        .cur_mask (cur_mask),
        .depth    (stk_depth),
        .overflow (stack_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q   <= 1'b0;
            ls_rdata <= '0;
        end else begin
            if (accept && instr_s.op == OP_HALT) begin
                done_q <= 1'b1;
            end
            if (ls_en && !ls_we) begin
                ls_rdata <= pe_rdata[ls_pe];
            end
        end
    end

endmodule

// File: rtl/simd_array_chk.sv
module simd_array_chk
    import simd_pkg::*;
#(
    parameter  int NUM_PE    = 8,
    parameter  int STK_DEPTH = 4,
    localparam int DEP_W     = $clog2(STK_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              accept,
    input opcode_t           op,
    input logic              instr_ready,
    input logic              done,
    input logic              stack_ovf,
    input logic [NUM_PE-1:0] cur_mask,
    input logic [DEP_W-1:0]  stk_depth
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stk_depth == '0 && cur_mask == '1 && !done && !stack_ovf));

    assert_push_narrows_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_SETMASK && stk_depth < DEP_W'(STK_DEPTH))
        |=> ((cur_mask & ~$past(cur_mask)) == '0));

    assert_flip_keeps_depth_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_ELSE) |=> $stable(stk_depth));

    assert_depth_bound_R6: assert property (@(posedge clk) disable iff (rst)
        stk_depth <= DEP_W'(STK_DEPTH));

    assert_pop_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_ENDIF && stk_depth == '0) |=> (stk_depth == '0));

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        stack_ovf |=> stack_ovf);

    assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(stack_ovf) |-> $past(accept && op == OP_SETMASK && stk_depth == DEP_W'(STK_DEPTH)));

    assert_ready_before_stop_R8: assert property (@(posedge clk) disable iff (rst)
        !done |-> instr_ready);

    assert_done_after_stop_R9: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_HALT) |=> done);

    assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> (done && !instr_ready));

endmodule

bind simd_array simd_array_chk #(
    .NUM_PE    (NUM_PE),
    .STK_DEPTH (STK_DEPTH)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .op          (instr_s.op),
    .instr_ready (instr_ready),
    .done        (done),
    .stack_ovf   (stack_ovf),
    .cur_mask    (cur_mask),
    .stk_depth   (stk_depth)
);

// File: tb/simd_array_bench.sv
module simd_array_bench;
    import simd_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic        instr_ready;
    logic [15:0] instr_word = '0;
    logic        ls_en = 1'b0;
    logic        ls_we = 1'b0;
    logic [2:0]  ls_pe = '0;
    logic [3:0]  ls_addr = '0;
    logic [15:0] ls_wdata = '0;
    logic [15:0] ls_rdata;
    logic        done;
    logic        stack_ovf;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    simd_array u_simd_array (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .instr_ready (instr_ready),
        .instr_word  (instr_word),
        .ls_en       (ls_en),
        .ls_we       (ls_we),
        .ls_pe       (ls_pe),
        .ls_addr     (ls_addr),
        .ls_wdata    (ls_wdata),
        .ls_rdata    (ls_rdata),
        .done        (done),
        .stack_ovf   (stack_ovf)
    );

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(int pe, int a, logic [15:0] d);
        ls_en = 1'b1; ls_we = 1'b1; ls_pe = pe[2:0]; ls_addr = a[3:0]; ls_wdata = d;
        @(negedge clk);
        ls_en = 1'b0; ls_we = 1'b0;
    endtask

    task automatic rd_reg(int pe, int a, output logic [15:0] d);
        ls_en = 1'b1; ls_we = 1'b0; ls_pe = pe[2:0]; ls_addr = a[3:0];
        @(negedge clk);
        ls_en = 1'b0;
        d = ls_rdata;
    endtask

    task automatic issue(opcode_t op, int rd, int ra, int rb);
        instr_valid = 1'b1;
        instr_word  = {op, rd[3:0], ra[3:0], rb[3:0]};
        @(negedge clk);
    endtask

    task automatic idle();
        instr_valid = 1'b0;
        instr_word  = '0;
    endtask

    function automatic logic [15:0] aval(int i);
        return 16'(10 * i + 5);
    endfunction

    task automatic check_reg(string req, int a, logic [15:0] exp [8]);
        logic [15:0] v;
        for (int i = 0; i < 8; i++) begin
            rd_reg(i, a, v);
            chk(req, $sformatf("pe%0d r%0d", i, a), v, exp[i]);
        end
    endtask

    task automatic t_reset();
        logic [15:0] z [8];
        for (int i = 0; i < 8; i++) z[i] = '0;
        chk("R1", "done", {15'd0, done}, 16'd0);
        chk("R1", "instr_ready", {15'd0, instr_ready}, 16'd1);
        chk("R1", "stack_ovf", {15'd0, stack_ovf}, 16'd0);
        check_reg("R1", 1, z);
        check_reg("R1", 15, z);
    endtask

    task automatic t_load_alu();
        logic [15:0] e [8];
        for (int i = 0; i < 8; i++) begin
            wr_reg(i, 1, aval(i));
            wr_reg(i, 2, 16'd20);
            wr_reg(i, 6, 16'd40);
            wr_reg(i, 10, 16'd60);
            wr_reg(i, 7, 16'hAAAA);
            wr_reg(i, 8, 16'h1234);
        end
        for (int i = 0; i < 8; i++) e[i] = aval(i);
        check_reg("R10", 1, e);
        issue(OP_ADD, 3, 1, 2);
        issue(OP_SUB, 4, 1, 2);
        issue(OP_MOV, 5, 1, 0);
        idle();
        for (int i = 0; i < 8; i++) e[i] = aval(i) + 16'd20;
        check_reg("R2", 3, e);
        for (int i = 0; i < 8; i++) e[i] = aval(i) - 16'd20;
        check_reg("R2", 4, e);
        for (int i = 0; i < 8; i++) e[i] = aval(i);
        check_reg("R2", 5, e);
    endtask

    task automatic t_if_else();
        logic [15:0] e [8];
        issue(OP_CMPGT, 0, 1, 6);
        issue(OP_SETMASK, 0, 0, 0);
        issue(OP_MOV, 7, 3, 0);
        issue(OP_ADD, 8, 1, 2);
        issue(OP_ELSE, 0, 0, 0);
        issue(OP_MOV, 7, 4, 0);
        issue(OP_ENDIF, 0, 0, 0);
        issue(OP_MOV, 9, 1, 0);
        idle();
        for (int i = 0; i < 8; i++) e[i] = (i >= 4) ? aval(i) + 16'd20 : aval(i) - 16'd20;
        check_reg("R3 R5", 7, e);
        for (int i = 0; i < 8; i++) e[i] = (i >= 4) ? aval(i) + 16'd20 : 16'h1234;
        check_reg("R4", 8, e);
        for (int i = 0; i < 8; i++) e[i] = aval(i);
        check_reg("R6", 9, e);
    endtask

    task automatic t_nested();
        logic [15:0] e [8];
        issue(OP_CMPGT, 0, 1, 6);
        issue(OP_SETMASK, 0, 0, 0);
        issue(OP_CMPGT, 0, 1, 10);
        issue(OP_SETMASK, 0, 0, 0);
        issue(OP_MOV, 11, 2, 0);
        issue(OP_ELSE, 0, 0, 0);
        issue(OP_MOV, 12, 2, 0);
        issue(OP_ENDIF, 0, 0, 0);
        issue(OP_ENDIF, 0, 0, 0);
        idle();
        for (int i = 0; i < 8; i++) e[i] = (i >= 6) ? 16'd20 : 16'd0;
        check_reg("R4", 11, e);
        for (int i = 0; i < 8; i++) e[i] = (i == 4 || i == 5) ? 16'd20 : 16'd0;
        check_reg("R5", 12, e);
    endtask

    task automatic t_overflow();
        logic [15:0] e [8];
        issue(OP_CMPGT, 0, 2, 0);
        for (int k = 0; k < 4; k++) issue(OP_SETMASK, 0, 0, 0);
        idle();
        chk("R7", "ovf at depth 4", {15'd0, stack_ovf}, 16'd0);
        issue(OP_SETMASK, 0, 0, 0);
        idle();
        chk("R7", "ovf after 5th push", {15'd0, stack_ovf}, 16'd1);
        issue(OP_MOV, 9, 2, 0);
        idle();
        for (int i = 0; i < 8; i++) e[i] = 16'd20;
        check_reg("R7", 9, e);
        for (int k = 0; k < 5; k++) issue(OP_ENDIF, 0, 0, 0);
        issue(OP_CMPGT, 0, 1, 6);
        issue(OP_SETMASK, 0, 0, 0);
        issue(OP_MOV, 9, 0, 0);
        issue(OP_ENDIF, 0, 0, 0);
        idle();
        for (int i = 0; i < 8; i++) e[i] = (i >= 4) ? 16'd0 : 16'd20;
        check_reg("R6", 9, e);
        chk("R7", "ovf sticky", {15'd0, stack_ovf}, 16'd1);
    endtask

    task automatic t_valid_low();
        logic [15:0] e [8];
        instr_valid = 1'b0;
        instr_word  = {OP_ADD, 4'd13, 4'd1, 4'd2};
        repeat (3) @(negedge clk);
        idle();
        for (int i = 0; i < 8; i++) e[i] = 16'd0;
        check_reg("R11", 13, e);
    endtask

    task automatic t_back_to_back();
        logic [15:0] e [8];
        chk("R8", "ready before stream", {15'd0, instr_ready}, 16'd1);
        issue(OP_MOV, 14, 1, 0);
        chk("R8", "ready mid stream", {15'd0, instr_ready}, 16'd1);
        issue(OP_ADD, 14, 14, 2);
        issue(OP_ADD, 14, 14, 2);
        idle();
        for (int i = 0; i < 8; i++) e[i] = aval(i) + 16'd40;
        check_reg("R8", 14, e);
    endtask

    task automatic t_halt();
        logic [15:0] e [8];
        issue(OP_HALT, 0, 0, 0);
        chk("R9", "done after stop", {15'd0, done}, 16'd1);
        chk("R9", "ready after stop", {15'd0, instr_ready}, 16'd0);
        issue(OP_MOV, 15, 1, 0);
        issue(OP_MOV, 15, 1, 0);
        idle();
        for (int i = 0; i < 8; i++) e[i] = 16'd0;
        check_reg("R9", 15, e);
        chk("R9", "done held", {15'd0, done}, 16'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load_alu();
        t_if_else();
        t_nested();
        t_overflow();
        t_valid_low();
        t_back_to_back();
        t_halt();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule